// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block takes a DRAM from power-up to a refreshed, usable state and then keeps it refreshed. Once reset is released it waits a programmable pause, then issues a fixed number of CAS-before-RAS (CBR) cycles on its own before it reports that the memory is ready. After that a tick timer marks each point at which one refresh becomes due. Refreshes that are due but not yet performed are kept in a saturating owed-refresh counter.

The block shares the RAS, CAS and WE strobes with an access controller through a request/grant pair. While it owes refreshes it raises `ref_req`. It raises `ref_urgent` once the owed count reaches a threshold, which tells the controller to end any open page. When it sees `ref_gnt` it runs one CBR cycle. It keeps `ref_req` high until the strobes are back at rest.

A low-power request makes the block perform a burst of CBR cycles that covers every row. It then enters self refresh straight away by holding the CBR pattern with RAS low. On leaving self refresh it keeps RAS high for a recovery time and performs a second full burst. Finally it clears the owed count and returns to distributed refresh. All times are parameters counted in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_n` and `we_n` are high, and `ref_req`, `ref_urgent`, `init_done` and `lp_active` are low.
- R2: No strobe falls during the first PAUSE_CYC clock cycles after reset is released.
- R3: After the pause exactly INIT_CNT CBR cycles are issued without any grant. Then `init_done` rises and stays high. `ref_req` is low until `init_done` is high.
- R4: Every CBR cycle has the same shape. CAS falls while RAS is high. CAS stays low for at least CSR_CYC cycles before RAS falls. RAS falls only while CAS is low. `we_n` is high whenever CAS is low.
- R5: In a normal CBR cycle CAS stays low for at least CHR_CYC cycles after RAS falls, and RAS stays low for exactly RAS_CYC cycles.
- R6: After a normal cycle, RAS is high for at least RP_CYC cycles before the next CAS fall.
- R7: The first refresh becomes due, and `ref_req` rises, exactly TICK_CYC cycles after `init_done` rises. Every later TICK_CYC cycles one more refresh is owed.
- R8: The owed count saturates at DEBT_MAX. A grant given after a long wait yields exactly DEBT_MAX CBR cycles, after which `ref_req` falls.
- R9: `ref_urgent` is high exactly when the owed count is at least URGENT_TH. With no grant it rises URGENT_TH*TICK_CYC cycles after `init_done`. It is never high without `ref_req`.
- R10: After initialization, a CBR cycle starts only while `ref_gnt` is high.
- R11: When `lp_req` is high and granted, exactly ROWS CBR cycles are issued back to back. Self refresh then begins at once: `lp_active` rises, and CAS and RAS are held low for as long as `lp_req` stays high and for no less than SELF_CYC cycles, even when `lp_req` is short.
- R12: On leaving self refresh, RAS stays high for at least SRX_CYC cycles. Exactly ROWS CBR cycles then follow. After that the owed count is zero, and the next refresh falls due TICK_CYC cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_req | input | 1 | Request to enter self refresh; dropping it requests exit |
| ref_gnt | input | 1 | Grant from the access controller; held while `ref_req` is high |
| ref_req | output | 1 | Refresh owed, low-power pending, or strobes in use by this block |
| ref_urgent | output | 1 | Owed count has reached URGENT_TH |
| init_done | output | 1 | Power-up pause and initialization cycles are complete |
| lp_active | output | 1 | Block is in its self-refresh hold |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low; kept high |

## Verification
The bench goes after the owed counter at its edges. A grant made long after saturation must yield exactly DEBT_MAX cycles: a counter that wraps would yield too few, and one that never stops would keep `ref_req` high. Self refresh is tried with `lp_req` held longer than SELF_CYC and with a pulse of a few cycles. A design that follows `lp_req` directly would release RAS early, before self refresh could engage. Timer restarts are checked by counting cycles to the first request after initialization and after leaving self refresh. A design that does not clear its state at exit would request too early. Every strobe edge is compared against the setup, hold and precharge windows, so a phase that is one cycle short shows up.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

    // Phase of the strobe engine
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,   // CAS low, RAS high
        PH_HOLD,    // both low, CAS hold window
        PH_ACT,     // RAS low, CAS high (or low in self refresh)
        PH_PRE      // both high, precharge or self-refresh recovery
    } cbr_phase_e;

    // Scheduler state
    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_INIT,
        ST_RUN,
        ST_CBR,
        ST_LP_IN,
        ST_SELF,
        ST_LP_OUT
    } sched_state_e;

endpackage

// File: rtl/refresh_debt_timer.sv
module refresh_debt_timer #(
    parameter int TICK_CYC = 1560,
    parameter int DEBT_MAX = 8,
    localparam int DW = $clog2(DEBT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          take,
    input  logic          clr,
    output logic [DW-1:0] debt
);

    localparam int TW = $clog2(TICK_CYC + 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYC - 1);
    localparam logic [DW-1:0] DMAX      = DW'(DEBT_MAX);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic [DW-1:0] debt;
    } tmr_t;

    tmr_t q, d;
    logic tick;

    always_comb begin
        d    = q;
        tick = 1'b0;
        if (clr) begin
            d.cnt  = '0;
            d.debt = '0;
        end else if (!en) begin
            d.cnt = '0;
        end else begin
            tick  = (q.cnt == TICK_LAST);
            d.cnt = tick ? '0 : q.cnt + 1'b1;
            if (tick && !take && q.debt != DMAX)
                d.debt = q.debt + 1'b1;
            else if (take && !tick && q.debt != '0)
                d.debt = q.debt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign debt = q.debt;

endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
    import refresh_sched_pkg::*;
#(
    parameter int CSR_CYC  = 1,
    parameter int CHR_CYC  = 1,
    parameter int RAS_CYC  = 5,
    parameter int RP_CYC   = 3,
    parameter int SELF_CYC = 10000,
    parameter int SRX_CYC  = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic self_mode,
    input  logic hold,
    output logic ready,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);

    localparam int SUM = CSR_CYC + CHR_CYC + RAS_CYC + RP_CYC + SELF_CYC + SRX_CYC;
    localparam int CW  = $clog2(SUM + 1);
    localparam logic [CW-1:0] CSR_LAST  = CW'(CSR_CYC - 1);
    localparam logic [CW-1:0] CHR_LAST  = CW'(CHR_CYC - 1);
    localparam logic [CW-1:0] ACT_LAST  = CW'(RAS_CYC - CHR_CYC - 1);
    localparam logic [CW-1:0] RP_LAST   = CW'(RP_CYC - 1);
    localparam logic [CW-1:0] SELF_LAST = CW'(SELF_CYC - 1);
    localparam logic [CW-1:0] SRX_LAST  = CW'(SRX_CYC - 1);

    typedef struct packed {
        cbr_phase_e    ph;
        logic [CW-1:0] cnt;
        logic          self_q;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        unique case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    d.ph     = PH_SETUP;
                    d.cnt    = '0;
                    d.self_q = self_mode;
                end
            end
            PH_SETUP: begin
                if (q.cnt == CSR_LAST) begin
                    d.ph  = PH_HOLD;
                    d.cnt = '0;
                end else d.cnt = q.cnt + 1'b1;
            end
            PH_HOLD: begin
                if (q.cnt == CHR_LAST) begin
                    d.ph  = PH_ACT;
                    d.cnt = '0;
                end else d.cnt = q.cnt + 1'b1;
            end
            PH_ACT: begin
                if (q.self_q) begin
                    // saturate at the minimum self-refresh width
                    if (q.cnt < SELF_LAST) d.cnt = q.cnt + 1'b1;
                    else if (!hold) begin
                        d.ph  = PH_PRE;
                        d.cnt = '0;
                    end
                end else if (q.cnt == ACT_LAST) begin
                    d.ph  = PH_PRE;
                    d.cnt = '0;
                end else d.cnt = q.cnt + 1'b1;
            end
            PH_PRE: begin
                if (q.cnt == (q.self_q ? SRX_LAST : RP_LAST)) begin
                    d.ph     = PH_IDLE;
                    d.cnt    = '0;
                    d.self_q = 1'b0;
                end else d.cnt = q.cnt + 1'b1;
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: PH_IDLE, cnt: '0, self_q: 1'b0};
        else        q <= d;
    end

    always_comb begin
        ready = (q.ph == PH_IDLE);
        ras_n = !(q.ph == PH_HOLD || q.ph == PH_ACT);
        cas_n = !(q.ph == PH_SETUP || q.ph == PH_HOLD ||
                  (q.ph == PH_ACT && q.self_q));
        we_n  = 1'b1;
    end

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import refresh_sched_pkg::*;
#(
    parameter int PAUSE_CYC = 20000,
    parameter int INIT_CNT  = 8,
    parameter int TICK_CYC  = 1560,
    parameter int DEBT_MAX  = 8,
    parameter int URGENT_TH = 4,
    parameter int ROWS      = 4096,
    parameter int CSR_CYC   = 1,
    parameter int CHR_CYC   = 1,
    parameter int RAS_CYC   = 5,
    parameter int RP_CYC    = 3,
    parameter int SELF_CYC  = 10000,
    parameter int SRX_CYC   = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_req,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ref_urgent,
    output logic init_done,
    output logic lp_active,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);

    localparam int M1  = (PAUSE_CYC > ROWS) ? PAUSE_CYC : ROWS;
    localparam int MX  = (M1 > INIT_CNT) ? M1 : INIT_CNT;
    localparam int CW  = $clog2(MX + 1);
    localparam int DW  = $clog2(DEBT_MAX + 1);
    localparam logic [CW-1:0] PAUSE_LAST = CW'(PAUSE_CYC - 1);
    localparam logic [CW-1:0] INIT_N     = CW'(INIT_CNT);
    localparam logic [CW-1:0] ROWS_N     = CW'(ROWS);
    localparam logic [DW-1:0] URG_N      = DW'(URGENT_TH);

    typedef struct packed {
        sched_state_e  st;
        logic [CW-1:0] cnt;
    } sch_t;

    sch_t q, d;
    logic          seq_start, seq_self, seq_ready;
    logic          debt_take, debt_clr, owns;
    logic [DW-1:0] debt;

    refresh_debt_timer #(
        .TICK_CYC (TICK_CYC),
        .DEBT_MAX (DEBT_MAX)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done),
        .take  (debt_take),
        .clr   (debt_clr),
        .debt  (debt)
    );

    cbr_strobe_seq #(
        .CSR_CYC  (CSR_CYC),
        .CHR_CYC  (CHR_CYC),
        .RAS_CYC  (RAS_CYC),
        .RP_CYC   (RP_CYC),
        .SELF_CYC (SELF_CYC),
        .SRX_CYC  (SRX_CYC)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (seq_start),
        .self_mode (seq_self),
        .hold      (lp_req),
        .ready     (seq_ready),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n)
    );

    always_comb begin
        d         = q;
        seq_start = 1'b0;
        seq_self  = 1'b0;
        debt_take = 1'b0;
        debt_clr  = 1'b0;
        unique case (q.st)
            ST_PAUSE: begin
                if (q.cnt == PAUSE_LAST) begin
                    d.st  = ST_INIT;
                    d.cnt = '0;
                end else d.cnt = q.cnt + 1'b1;
            end
            ST_INIT: begin
                if (seq_ready) begin
                    if (q.cnt == INIT_N) begin
                        d.st  = ST_RUN;
                        d.cnt = '0;
                    end else begin
                        seq_start = 1'b1;
                        d.cnt     = q.cnt + 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (ref_gnt && seq_ready) begin
                    if (lp_req) begin
                        d.st  = ST_LP_IN;
                        d.cnt = '0;
                    end else if (debt != '0) begin
                        seq_start = 1'b1;
                        debt_take = 1'b1;
                        d.st      = ST_CBR;
                    end
                end
            end
            ST_CBR: begin
                if (seq_ready) d.st = ST_RUN;
            end
            ST_LP_IN: begin
                if (seq_ready) begin
                    seq_start = 1'b1;
                    if (q.cnt == ROWS_N) begin
                        // all rows fresh: enter self refresh at once
                        seq_self = 1'b1;
                        d.st     = ST_SELF;
                        d.cnt    = '0;
                    end else d.cnt = q.cnt + 1'b1;
                end
            end
            ST_SELF: begin
                if (seq_ready) begin
                    d.st  = ST_LP_OUT;
                    d.cnt = '0;
                end
            end
            ST_LP_OUT: begin
                if (seq_ready) begin
                    if (q.cnt == ROWS_N) begin
                        debt_clr = 1'b1;
                        d.st     = ST_RUN;
                        d.cnt    = '0;
                    end else begin
                        seq_start = 1'b1;
                        d.cnt     = q.cnt + 1'b1;
                    end
                end
            end
            default: d.st = ST_PAUSE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_PAUSE, cnt: '0};
        else        q <= d;
    end

    always_comb begin
        init_done  = !(q.st == ST_PAUSE || q.st == ST_INIT);
        owns       = (q.st == ST_CBR || q.st == ST_LP_IN ||
                      q.st == ST_SELF || q.st == ST_LP_OUT);
        ref_req    = init_done && (debt != '0 || lp_req || owns);
        ref_urgent = init_done && (debt >= URG_N);
        lp_active  = (q.st == ST_SELF);
    end

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic lp_req,
    input logic ref_gnt,
    input logic ref_req,
    input logic ref_urgent,
    input logic init_done,
    input logic lp_active,
    input logic ras_n,
    input logic cas_n,
    input logic we_n
);

    // R4
    cas_fall_ras_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> ras_n);

    // R4
    ras_fall_cbr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && !$past(cas_n)));

    // R4
    we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> we_n);

    // R9
    urgent_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> ref_req);

    // R3
    init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R3
    no_req_before_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !ref_req);

    // R11
    self_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_active && lp_req && !ras_n) |=> !ras_n);

endmodule

bind dram_refresh_sched refresh_sched_chk i_chk (.*);

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;

    localparam int CLK_PERIOD = 10;
    localparam int PAUSE_CYC  = 60;
    localparam int INIT_CNT   = 8;
    localparam int TICK_CYC   = 200;
    localparam int DEBT_MAX   = 8;
    localparam int URGENT_TH  = 4;
    localparam int ROWS       = 6;
    localparam int CSR_CYC    = 2;
    localparam int CHR_CYC    = 2;
    localparam int RAS_CYC    = 5;
    localparam int RP_CYC     = 3;
    localparam int SELF_CYC   = 40;
    localparam int SRX_CYC    = 6;

    logic clk = 1'b0;
    logic rst_n, lp_req, ref_gnt;
    logic ref_req, ref_urgent, init_done, lp_active, ras_n, cas_n, we_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_refresh_sched #(
        .PAUSE_CYC (PAUSE_CYC), .INIT_CNT (INIT_CNT), .TICK_CYC (TICK_CYC),
        .DEBT_MAX (DEBT_MAX), .URGENT_TH (URGENT_TH), .ROWS (ROWS),
        .CSR_CYC (CSR_CYC), .CHR_CYC (CHR_CYC), .RAS_CYC (RAS_CYC),
        .RP_CYC (RP_CYC), .SELF_CYC (SELF_CYC), .SRX_CYC (SRX_CYC)
    ) i_dram_refresh_sched (
        .clk (clk), .rst_n (rst_n), .lp_req (lp_req), .ref_gnt (ref_gnt),
        .ref_req (ref_req), .ref_urgent (ref_urgent), .init_done (init_done),
        .lp_active (lp_active), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // expected windows from the requirements
    function automatic int pre_min(input bit after_self);
        return after_self ? SRX_CYC : RP_CYC;
    endfunction

    // strobe monitor
    int  cyc = 0, cbr_cnt = 0;
    int  cas_low_len = 0, ras_low_len = 0, ras_high_len = 1000;
    bit  prev_ras = 1'b1, prev_cas = 1'b1, seen_lp = 1'b0, after_self = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!cas_n && prev_cas) begin
                chk(cyc >= PAUSE_CYC, "R2 cas fall cycle", cyc, PAUSE_CYC);
                chk(ras_n, "R4 ras high at cas fall", ras_n, 1);
                chk(ras_high_len >= pre_min(after_self), "R6/R12 precharge",
                    ras_high_len, pre_min(after_self));
                if (init_done) chk(ref_gnt, "R10 grant at cycle start", ref_gnt, 1);
            end
            if (!ras_n && prev_ras) begin
                chk(!cas_n && cas_low_len >= CSR_CYC, "R4 cas setup", cas_low_len, CSR_CYC);
                chk(we_n, "R4 we high", we_n, 1);
                cbr_cnt++;
                seen_lp = lp_active;
            end
            if (cas_n && !prev_cas && !prev_ras)
                chk(ras_low_len >= CHR_CYC, "R5 cas hold", ras_low_len, CHR_CYC);
            if (ras_n && !prev_ras) begin
                if (seen_lp) begin
                    chk(ras_low_len >= SELF_CYC, "R11 self width", ras_low_len, SELF_CYC);
                    after_self = 1'b1;
                end else begin
                    chk(ras_low_len == RAS_CYC, "R5 ras width", ras_low_len, RAS_CYC);
                    after_self = 1'b0;
                end
            end
            cas_low_len  = cas_n ? 0 : cas_low_len + 1;
            ras_low_len  = ras_n ? 0 : ras_low_len + 1;
            ras_high_len = ras_n ? ras_high_len + 1 : 0;
            prev_ras = ras_n;
            prev_cas = cas_n;
            cyc++;
        end
    end

    task automatic drain();
        ref_gnt = 1'b1;
        while (ref_req) @(negedge clk);
        ref_gnt = 1'b0;
    endtask

    task automatic self_cycle(input int hold_cyc);
        lp_req  = 1'b1;
        ref_gnt = 1'b1;
        while (!lp_active) @(negedge clk);
        repeat (hold_cyc) @(negedge clk);
        lp_req = 1'b0;
        while (lp_active) @(negedge clk);
        while (ref_req) @(negedge clk);
        ref_gnt = 1'b0;
    endtask

    initial begin
        int n, c0;
        int unsigned r;
        rst_n = 1'b0; lp_req = 1'b0; ref_gnt = 1'b0;
        r = $urandom(32'd1234);
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(ras_n && cas_n && we_n, "R1 strobes idle", {ras_n, cas_n, we_n}, 7);
        chk(!ref_req && !ref_urgent, "R1 no request", {ref_req, ref_urgent}, 0);
        chk(!init_done && !lp_active, "R1 not ready", {init_done, lp_active}, 0);
        rst_n = 1'b1;

        // R3 initialization
        while (!init_done) @(negedge clk);
        chk(cbr_cnt == INIT_CNT, "R3 init cycles", cbr_cnt, INIT_CNT);

        // R7 first due refresh, R9 urgency
        n = 0;
        while (!ref_req) begin @(negedge clk); n++; end
        chk(n == TICK_CYC, "R7 first tick", n, TICK_CYC);
        chk(!ref_urgent, "R9 not urgent at one owed", ref_urgent, 0);
        while (!ref_urgent) begin @(negedge clk); n++; end
        chk(n == URGENT_TH * TICK_CYC, "R9 urgent time", n, URGENT_TH * TICK_CYC);

        // R8 saturation
        repeat ((DEBT_MAX + 3 - URGENT_TH) * TICK_CYC) @(negedge clk);
        c0 = cbr_cnt;
        drain();
        chk(cbr_cnt - c0 == DEBT_MAX, "R8 drained count", cbr_cnt - c0, DEBT_MAX);
        chk(!ref_urgent, "R9 urgency cleared", ref_urgent, 0);

        // R11/R12 long self refresh
        @(negedge clk);
        c0 = cbr_cnt;
        lp_req = 1'b1; ref_gnt = 1'b1;
        while (!lp_active) @(negedge clk);
        chk(cbr_cnt - c0 == ROWS, "R11 entry burst", cbr_cnt - c0, ROWS);
        repeat (SELF_CYC + 20) @(negedge clk);
        chk(!ras_n && !cas_n, "R11 held while requested", {ras_n, cas_n}, 0);
        lp_req = 1'b0;
        while (lp_active) @(negedge clk);
        c0 = cbr_cnt;
        while (ref_req) @(negedge clk);
        ref_gnt = 1'b0;
        chk(cbr_cnt - c0 == ROWS, "R12 exit burst", cbr_cnt - c0, ROWS);
        n = 0;
        while (!ref_req) begin @(negedge clk); n++; end
        chk(n == TICK_CYC, "R12 timer restart", n, TICK_CYC);

        // R11 short low-power pulse still gives full self width
        self_cycle(3);
        chk(!ref_req, "R11 short pulse done", ref_req, 0);

        // random mix of waits, grants and self refresh
        for (int i = 0; i < 25; i++) begin
            repeat ($urandom % (3 * TICK_CYC)) @(negedge clk);
            if ($urandom % 5 == 0) self_cycle($urandom % (2 * SELF_CYC));
            else drain();
            chk(!ref_req && !ref_urgent, "R8 idle after service", ref_req, 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule